// File: doc/BRIEF.md
# Reference Clock Qualifier and Selector

This block watches four raw reference clocks from the local-oscillator clock domain and nominates one of them as the reference for a downstream digital PLL. Every input passes through an optional inversion and a two-flop synchroniser. It then feeds two monitors. The activity monitor drops an input quickly once its edges stop arriving. The frequency monitor counts the input's rising edges over a fixed window of local cycles. It rejects the input if the count falls outside a programmed band, and it accepts the input again only after several windows in a row that fall inside the band. An input is valid when both monitors accept it.

A three-state machine picks the reference. ST_LOST means nothing usable is selected. ST_AUTO means the best valid input is followed by priority. ST_MANUAL means a register forces the index. The machine moves along these transitions:
- ST_LOST→ST_AUTO when a valid input with nonzero priority appears.
- ST_AUTO→ST_LOST when the current input fails and no other candidate exists.
- ST_LOST→ST_MANUAL and ST_AUTO→ST_MANUAL when manual mode is set.
- ST_MANUAL→ST_AUTO when manual mode is cleared. ST_AUTO then re-evaluates the retained index on the next cycle.

In ST_AUTO the machine can work revertively, moving to a better input once that input requalifies. It can also work nonrevertively, holding the current input while that input stays valid. Each change of the selected index produces a one-cycle strobe that downstream phase build-out can use. A registered all-lost flag tells the PLL to enter holdover.

Top module: `refmon_top`

## Requirements
- R1: An input's `ref_active` bit rises on the third clock edge after a rising transition of the (possibly inverted) input. It clears once `miss` consecutive local cycles pass without such an edge. The miss limit is held in register 1, bits [11:0].
- R2: Bit i of register 0 inverts input i before the monitors. With the bit clear, a falling raw transition is not counted as an edge. With the bit set, a falling raw transition is counted as an edge.
- R3: The window lasts WIN_LEN local cycles. At the end of each window, `ref_freq_ok` clears for any input whose rising-edge count lies outside [low, high]. The low bound is in register 2 and the high bound is in register 3, both in bits [11:0].
- R4: `ref_freq_ok` sets only after HYST_WINS consecutive in-band windows. `ref_valid` is the AND of the active flag and the frequency flag.
- R5: In automatic mode the selector takes the valid input with the highest nonzero priority, and the lower index wins ties. Priority 0 excludes an input even when it is valid. The priority of input i is in register 4, bits [4i+3:4i].
- R6: In revertive mode (register 5 bit 1 = 1), the selector switches to a valid input of strictly higher priority than the current one.
- R7: In nonrevertive mode (register 5 bit 1 = 0), the selector keeps the current input while that input is valid and has nonzero priority.
- R8: When the current input loses validity or priority, the selector moves to the best remaining candidate. If no candidate remains, it enters ST_LOST and drops `sel_valid`.
- R9: With register 5 bit 0 = 1, `sel_idx` equals register 5 bits [3:2] from the clock edge after the register write, whatever the validity of that input. `sel_valid` shows that input's validity.
- R10: `all_lost` is high in the cycle after a cycle in which no input was valid. `sel_valid` is low whenever no input is valid.
- R11: `sw_strobe` is high for exactly the cycles in which `sel_idx` differs from its value in the previous cycle.
- R12: After reset, `sel_idx` is 0, `sel_valid`, `sw_strobe` and all status bits are 0, and `all_lost` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 4 | Raw reference clock inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 invert, 1 miss, 2 low, 3 high, 4 priority, 5 mode) |
| wr_data | input | 16 | Register write data |
| sel_idx | output | 2 | Selected reference index |
| sel_valid | output | 1 | Selected reference is usable |
| all_lost | output | 1 | No input was valid in the previous cycle |
| sw_strobe | output | 1 | One-cycle pulse on a change of selection |
| ref_active | output | 4 | Per-input activity status |
| ref_freq_ok | output | 4 | Per-input frequency status |
| ref_valid | output | 4 | Per-input qualification |

## Verification
The timing is as follows:
- A register write lands on the edge that samples `wr_en`.
- A manual selection and its strobe appear on the following edge, so the bench checks the old index at the first falling edge after the write and the new index plus the strobe at the second.
- An input transition reaches `ref_active` on the third rising edge, so the bench samples the bit one falling edge early, where it must be unchanged, and then at the third falling edge.

The frequency and selection results depend on where the window boundaries fall, and the bench cannot see them. For those results the bench waits more than the worst case of HYST_WINS plus one windows. For hysteresis it measures the time to requalification and requires it to exceed a full window.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
    typedef enum logic [1:0] {
        ST_LOST   = 2'd0,
        ST_AUTO   = 2'd1,
        ST_MANUAL = 2'd2
    } sel_state_t;

    localparam logic [2:0] ADR_INVERT = 3'd0;
    localparam logic [2:0] ADR_MISS   = 3'd1;
    localparam logic [2:0] ADR_LOW    = 3'd2;
    localparam logic [2:0] ADR_HIGH   = 3'd3;
    localparam logic [2:0] ADR_PRIO   = 3'd4;
    localparam logic [2:0] ADR_MODE   = 3'd5;
endpackage

// File: rtl/refmon_act.sv
module refmon_act #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             invert,
    input  logic [CNT_W-1:0] miss_lim,
    output logic             edge_p,
    output logic             active
);
    logic [2:0]       sync_q;
    logic [CNT_W-1:0] gap_q;

    assign edge_p = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            gap_q  <= '0;
            active <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], raw ^ invert};
            if (edge_p) begin
                gap_q  <= '0;
                active <= 1'b1;
            end else if (gap_q >= miss_lim) begin
                active <= 1'b0;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/refmon_freq.sv
module refmon_freq #(
    parameter int CNT_W     = 12,
    parameter int HYST_WINS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_p,
    input  logic             win_end,
    input  logic [CNT_W-1:0] low,
    input  logic [CNT_W-1:0] high,
    output logic             freq_ok
);
    localparam int HYST_W = $clog2(HYST_WINS + 1);
    localparam logic [HYST_W-1:0] HYST_LAST = HYST_W'(HYST_WINS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [HYST_W-1:0] good_q;
    logic [CNT_W:0]    total;
    logic              in_band;

    assign total   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, edge_p};
    assign in_band = (total >= {1'b0, low}) && (total <= {1'b0, high});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            good_q  <= '0;
            freq_ok <= 1'b0;
        end else if (win_end) begin
            cnt_q <= '0;
            if (!in_band) begin
                freq_ok <= 1'b0;
                good_q  <= '0;
            end else if (good_q >= HYST_LAST) begin
                freq_ok <= 1'b1;
            end else begin
                good_q <= good_q + 1'b1;
            end
        end else if (edge_p && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/refmon_sel.sv
module refmon_sel
    import refmon_pkg::*;
#(
    parameter int NUM_REF = 4,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REF-1:0]        valid,
    input  logic [NUM_REF*PRIO_W-1:0] prio,
    input  logic                      manual,
    input  logic                      revert,
    input  logic [IDX_W-1:0]          manual_idx,
    output logic [IDX_W-1:0]          sel_idx,
    output logic                      sel_valid,
    output logic                      all_lost,
    output logic                      sw_strobe
);
    sel_state_t       state_q, state_d;
    logic [IDX_W-1:0] sel_d;
    logic [IDX_W-1:0] best_idx;
    logic [PRIO_W-1:0] best_prio, cur_prio;
    logic             best_found, cur_ok;

    always_comb begin
        best_idx   = '0;
        best_prio  = '0;
        best_found = 1'b0;
        for (int i = 0; i < NUM_REF; i++) begin
            if (valid[i] && (prio[i*PRIO_W +: PRIO_W] > best_prio)) begin
                best_idx   = IDX_W'(i);
                best_prio  = prio[i*PRIO_W +: PRIO_W];
                best_found = 1'b1;
            end
        end
    end

    assign cur_prio = prio[sel_idx*PRIO_W +: PRIO_W];
    assign cur_ok   = valid[sel_idx] && (cur_prio != '0);

    always_comb begin
        state_d = state_q;
        sel_d   = sel_idx;
        unique case (state_q)
            ST_LOST: begin
                if (manual) begin
                    state_d = ST_MANUAL;
                    sel_d   = manual_idx;
                end else if (best_found) begin
                    state_d = ST_AUTO;
                    sel_d   = best_idx;
                end
            end
            ST_AUTO: begin
                if (manual) begin
                    state_d = ST_MANUAL;
                    sel_d   = manual_idx;
                end else if (!cur_ok) begin
                    if (best_found) sel_d = best_idx;
                    else            state_d = ST_LOST;
                end else if (revert && best_found && (best_prio > cur_prio)) begin
                    sel_d = best_idx;
                end
            end
            ST_MANUAL: begin
                if (manual) sel_d = manual_idx;
                else        state_d = ST_AUTO;
            end
            default: state_d = ST_LOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_LOST;
            sel_idx   <= '0;
            sw_strobe <= 1'b0;
            all_lost  <= 1'b1;
        end else begin
            state_q   <= state_d;
            sel_idx   <= sel_d;
            sw_strobe <= (sel_d != sel_idx);
            all_lost  <= (valid == '0);
        end
    end

    always_comb begin
        sel_valid = (state_q != ST_LOST) && valid[sel_idx];
    end
endmodule

// File: rtl/refmon_top.sv
module refmon_top
    import refmon_pkg::*;
#(
    parameter int NUM_REF   = 4,
    parameter int CNT_W     = 12,
    parameter int PRIO_W    = 4,
    parameter int DATA_W    = 16,
    parameter int WIN_LEN   = 256,
    parameter int HYST_WINS = 2,
    parameter int IDX_W     = $clog2(NUM_REF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REF-1:0] ref_in,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [IDX_W-1:0]   sel_idx,
    output logic               sel_valid,
    output logic               all_lost,
    output logic               sw_strobe,
    output logic [NUM_REF-1:0] ref_active,
    output logic [NUM_REF-1:0] ref_freq_ok,
    output logic [NUM_REF-1:0] ref_valid
);
    localparam int WIN_W  = $clog2(WIN_LEN);
    localparam int PRIO_T = NUM_REF * PRIO_W;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

    logic [NUM_REF-1:0] invert_q;
    logic [CNT_W-1:0]   miss_q, low_q, high_q;
    logic [PRIO_T-1:0]  prio_q;
    logic               manual_q, revert_q;
    logic [IDX_W-1:0]   manual_idx_q;
    logic [WIN_W-1:0]   win_q;
    logic               win_end;
    logic [NUM_REF-1:0] edge_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            invert_q     <= '0;
            miss_q       <= CNT_W'(16);
            low_q        <= '0;
            high_q       <= '1;
            prio_q       <= '0;
            manual_q     <= 1'b0;
            revert_q     <= 1'b1;
            manual_idx_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_INVERT: invert_q <= wr_data[NUM_REF-1:0];
                ADR_MISS:   miss_q   <= wr_data[CNT_W-1:0];
                ADR_LOW:    low_q    <= wr_data[CNT_W-1:0];
                ADR_HIGH:   high_q   <= wr_data[CNT_W-1:0];
                ADR_PRIO:   prio_q   <= wr_data[PRIO_T-1:0];
                ADR_MODE: begin
                    manual_q     <= wr_data[0];
                    revert_q     <= wr_data[1];
                    manual_idx_q <= wr_data[2 +: IDX_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        win_q <= '0;
        else if (win_end)  win_q <= '0;
        else               win_q <= win_q + 1'b1;
    end
    assign win_end = (win_q == WIN_LAST);

    for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
        refmon_act #(.CNT_W(CNT_W)) u_act (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (ref_in[g]),
            .invert   (invert_q[g]),
            .miss_lim (miss_q),
            .edge_p   (edge_p[g]),
            .active   (ref_active[g])
        );
        refmon_freq #(.CNT_W(CNT_W), .HYST_WINS(HYST_WINS)) u_freq (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_p  (edge_p[g]),
            .win_end (win_end),
            .low     (low_q),
            .high    (high_q),
            .freq_ok (ref_freq_ok[g])
        );
    end

    assign ref_valid = ref_active & ref_freq_ok;

    refmon_sel #(.NUM_REF(NUM_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (ref_valid),
        .prio       (prio_q),
        .manual     (manual_q),
        .revert     (revert_q),
        .manual_idx (manual_idx_q),
        .sel_idx    (sel_idx),
        .sel_valid  (sel_valid),
        .all_lost   (all_lost),
        .sw_strobe  (sw_strobe)
    );
endmodule

// File: rtl/refmon_chk.sv
module refmon_chk #(
    parameter int NUM_REF = 4,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [IDX_W-1:0]          sel_idx,
    input logic                      sel_valid,
    input logic                      all_lost,
    input logic                      sw_strobe,
    input logic [NUM_REF-1:0]        ref_valid,
    input logic                      manual_q,
    input logic                      revert_q,
    input logic [IDX_W-1:0]          manual_idx_q,
    input logic [NUM_REF*PRIO_W-1:0] prio_q
);
    logic [PRIO_W-1:0] cur_prio;
    assign cur_prio = prio_q[sel_idx*PRIO_W +: PRIO_W];

    a_r11_strobe_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        sw_strobe |-> (sel_idx != $past(sel_idx)));

    a_r11_change_gives_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_idx != $past(sel_idx)) |-> sw_strobe);

    a_r10_flag_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_valid) == '0) |-> all_lost);

    a_r10_no_sel_when_none: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid == '0) |-> !sel_valid);

    a_r9_manual_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(manual_q) |-> (sel_idx == $past(manual_idx_q)));

    a_r7_hold_current: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(manual_q) && !$past(revert_q) && $past(sel_valid) && ($past(cur_prio) != '0))
        |-> $stable(sel_idx));

    a_r8_selected_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ref_valid[sel_idx]);
endmodule

bind refmon_top refmon_chk #(
    .NUM_REF (NUM_REF),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_idx      (sel_idx),
    .sel_valid    (sel_valid),
    .all_lost     (all_lost),
    .sw_strobe    (sw_strobe),
    .ref_valid    (ref_valid),
    .manual_q     (manual_q),
    .revert_q     (revert_q),
    .manual_idx_q (manual_idx_q),
    .prio_q       (prio_q)
);

// File: tb/refmon_top_bench.sv
module refmon_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ref_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  sel_idx;
    logic        sel_valid, all_lost, sw_strobe;
    logic [3:0]  ref_active, ref_freq_ok, ref_valid;

    int half [4] = '{0, 0, 0, 0};
    int hc   [4] = '{0, 0, 0, 0};
    int chk_cnt = 0;
    int fail_cnt = 0;
    int strobes = 0;
    bit done = 0;

    always #2 clk = ~clk;

    refmon_top u_refmon_top (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sel_idx(sel_idx),
        .sel_valid(sel_valid), .all_lost(all_lost), .sw_strobe(sw_strobe),
        .ref_active(ref_active), .ref_freq_ok(ref_freq_ok), .ref_valid(ref_valid)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (sw_strobe) strobes++;
            for (int i = 0; i < 4; i++) begin
                if (half[i] != 0) begin
                    if (hc[i] >= half[i] - 1) begin
                        ref_in[i] = ~ref_in[i];
                        hc[i] = 0;
                    end else begin
                        hc[i] = hc[i] + 1;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        chk_cnt++;
        if (got != exp) begin
            fail_cnt++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 sel_idx", int'(sel_idx), 0);
        chk("R12 sel_valid", int'(sel_valid), 0);
        chk("R12 all_lost", int'(all_lost), 1);
        chk("R12 sw_strobe", int'(sw_strobe), 0);
        chk("R12 status", int'({ref_active, ref_freq_ok, ref_valid}), 0);
    endtask

    task automatic t_auto_pick;
        write_reg(3'd1, 16'd20);
        write_reg(3'd2, 16'd30);
        write_reg(3'd3, 16'd34);
        write_reg(3'd4, 16'h2331);
        write_reg(3'd5, 16'h0002);
        for (int i = 0; i < 4; i++) half[i] = 4;
        wait_n(1100);
        chk("R4 all valid", int'(ref_valid), 15);
        chk("R5 tie lower index", int'(sel_idx), 1);
        chk("R5 sel_valid", int'(sel_valid), 1);
    endtask

    task automatic t_loss_switch;
        int s0;
        s0 = strobes;
        half[1] = 0;
        wait_n(40);
        chk("R1 active cleared", int'(ref_active[1]), 0);
        chk("R8 moved to next", int'(sel_idx), 2);
        chk("R11 one strobe", strobes - s0, 1);
    endtask

    task automatic t_freq_fault;
        half[2] = 3;
        wait_n(600);
        chk("R3 freq_ok cleared", int'(ref_freq_ok[2]), 0);
        chk("R3 still active", int'(ref_active[2]), 1);
        chk("R8 moved on fault", int'(sel_idx), 3);
    endtask

    task automatic t_revert;
        int n;
        half[1] = 4;
        half[2] = 4;
        n = 0;
        while (!ref_freq_ok[1] && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R4 hysteresis delay", int'(n > 256 && n <= 800), 1);
        wait_n(600);
        chk("R6 returned to higher priority", int'(sel_idx), 1);
    endtask

    task automatic t_nonrevert;
        write_reg(3'd5, 16'h0000);
        half[1] = 0;
        wait_n(100);
        chk("R8 left failed input", int'(sel_idx), 2);
        half[1] = 4;
        wait_n(1100);
        chk("R7 requalified input valid", int'(ref_valid[1]), 1);
        chk("R7 kept current", int'(sel_idx), 2);
    endtask

    task automatic t_prio_zero;
        write_reg(3'd4, 16'h2031);
        wait_n(5);
        chk("R5 priority zero excluded", int'(sel_idx), 1);
        chk("R5 excluded input still valid", int'(ref_valid[2]), 1);
    endtask

    task automatic t_manual;
        write_reg(3'd5, 16'h0001);
        chk("R9 not before next edge", int'(sel_idx), 1);
        @(negedge clk);
        chk("R9 manual index", int'(sel_idx), 0);
        chk("R11 strobe on manual", int'(sw_strobe), 1);
        @(negedge clk);
        chk("R11 strobe one cycle", int'(sw_strobe), 0);
    endtask

    task automatic t_invert;
        half[3] = 0;
        ref_in[3] = 1'b1;
        wait_n(50);
        chk("R1 stuck input inactive", int'(ref_active[3]), 0);
        ref_in[3] = 1'b0;
        wait_n(8);
        chk("R2 falling ignored", int'(ref_active[3]), 0);
        write_reg(3'd0, 16'h0008);
        wait_n(6);
        chk("R2 inverted falling counted", int'(ref_active[3]), 1);
        wait_n(50);
        ref_in[3] = 1'b1;
        wait_n(8);
        chk("R2 inverted rising ignored", int'(ref_active[3]), 0);
        ref_in[3] = 1'b0;
        wait_n(2);
        chk("R1 not before third edge", int'(ref_active[3]), 0);
        wait_n(1);
        chk("R1 active on third edge", int'(ref_active[3]), 1);
    endtask

    task automatic t_manual_invalid;
        wait_n(40);
        write_reg(3'd5, 16'h000D);
        @(negedge clk);
        chk("R9 forced to invalid input", int'(sel_idx), 3);
        chk("R9 sel_valid shows input", int'(sel_valid), 0);
        write_reg(3'd0, 16'h0000);
    endtask

    task automatic t_all_lost;
        write_reg(3'd5, 16'h0000);
        for (int i = 0; i < 4; i++) half[i] = 0;
        wait_n(300);
        chk("R10 none valid", int'(ref_valid), 0);
        chk("R10 all_lost", int'(all_lost), 1);
        chk("R10 sel_valid low", int'(sel_valid), 0);
        half[0] = 4;
        wait_n(1100);
        chk("R5 recovered to only input", int'(sel_idx), 0);
        chk("R5 recovered valid", int'(sel_valid), 1);
        chk("R10 all_lost cleared", int'(all_lost), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk_cnt++;
            fail_cnt++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_auto_pick();
        t_loss_switch();
        t_freq_fault();
        t_revert();
        t_nonrevert();
        t_prio_zero();
        t_manual();
        t_invert();
        t_manual_invalid();
        t_all_lost();
        done = 1;
        $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
        $finish;
    end
endmodule